// File: doc/BRIEF.md
# Segmented Data Memory Address Unit

This unit turns the 8-bit data addresses of a small microcontroller core into 16-bit physical RAM addresses. The lower half of the byte space (0x00 to 0x7F) is widened by an 8-bit segment register, so each segment is a 128-byte window at a multiple of 256. The upper half (0x80 to 0xFF) always maps to physical 0x0080 to 0x00FF, whatever the segment register holds. That keeps the top region reachable at all times.

The top sixteen byte addresses hold registers, not RAM. Twelve are general-purpose. Three are the memory pointers: alternate pointer X, stack pointer SP and base pointer B. The last one is the segment register S. A request names an operation and an address source. The source is either a direct byte address or one of the three pointers. B and X may be stepped up or down after the access.

Two further operations act only on the register block. One loads an immediate value. The other decrements a register and reports through a skip flag whether the result reached zero. Reads return their data one cycle after the request, from the register block or from the RAM port.

Top module: `dmem_seg_unit`

## Requirements
- R1: For an effective address with bit 7 clear, ram_addr is S*256 + (address & 0x7F), driven combinationally in the cycle of the request.
- R2: For an effective address with bit 7 set, ram_addr is 0x00 in the upper byte and the address in the lower byte, independent of S.
- R3: Byte addresses 0xF0 to 0xFF select registers: 0xF0 to 0xFB are general, 0xFC is X, 0xFD is SP, 0xFE is B and 0xFF is S. Reads (op 1) and writes (op 2) there reach the register, never assert ram_re or ram_we, and a read returns the register value.
- R4: req_src selects the address: 0 uses req_addr directly, 1 uses B, 2 uses X and 3 uses SP. The pointer value goes through the same mapping as a direct address.
- R5: On a read or write through B or X, req_post 1 adds one and req_post 2 subtracts one from that pointer after the access. The access itself uses the old value. The step wraps modulo 256 and never changes S. req_post has no effect for direct or SP accesses.
- R6: After reset, SP holds 0x6F with the default RAM_BYTES of 128, or 0x2F with RAM_BYTES of 64. S, X, B and the general registers hold 0, and rd_valid and skip are low.
- R7: A write to S changes the address mapping from the very next request on.
- R8: Op 3 loads req_wdata into the register at direct address 0xF0 to 0xFE. At 0xFF or at an address below 0xF0 it changes nothing and drives no RAM strobe.
- R9: Op 4 at direct address 0xF0 to 0xFE writes back the register value minus one, wrapping from 0 to 0xFF. In the next cycle skip is 1 exactly when the result is zero. At any other address op 4 changes nothing and skip stays 0.
- R10: A read of an unmapped address (op 1) asserts ram_re in its request cycle. In the following cycle rd_valid is 1 and rd_data equals ram_rdata.
- R11: When a write through B or X with a post step targets that same pointer's own register, the post step wins over the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 none, 1 read, 2 write, 3 load immediate, 4 decrement and test |
| req_src | input | 2 | 0 direct, 1 B, 2 X, 3 SP |
| req_post | input | 2 | 0 none, 1 post-increment, 2 post-decrement |
| req_addr | input | 8 | Direct byte address |
| req_wdata | input | 8 | Write data or immediate value |
| rd_data | output | 8 | Read result, one cycle after the request |
| rd_valid | output | 1 | rd_data holds a read result |
| skip | output | 1 | Decrement result was zero |
| ram_addr | output | 16 | Physical RAM address |
| ram_re | output | 1 | RAM read strobe |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after ram_re |

## Verification
A wrong segment value shows at once on ram_addr for the next low-half request. A upper-half request shows nothing, so the bench compares both halves after each change of S. A pointer that stepped wrongly, or that S picked up a carry, only shows when the pointer is next used or read back through 0xFC to 0xFE. For that reason every step is followed directly by a read of the pointer and of S. A mis-decremented register shows on skip one cycle later and in its read-back value.

// File: rtl/dmem_seg_pkg.sv
package dmem_seg_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PHYS_W = 2 * BYTE_W;
  localparam int unsigned NREG   = 16;
  localparam int unsigned IDX_X  = 12;
  localparam int unsigned IDX_SP = 13;
  localparam int unsigned IDX_B  = 14;
  localparam int unsigned IDX_S  = 15;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0, OP_RD = 3'd1, OP_WR = 3'd2, OP_LDI = 3'd3, OP_DSZ = 3'd4
  } mem_op_e;

  typedef enum logic [1:0] {
    SRC_DIR = 2'd0, SRC_B = 2'd1, SRC_X = 2'd2, SRC_SP = 2'd3
  } addr_src_e;

  typedef enum logic [1:0] {
    PM_NONE = 2'd0, PM_INC = 2'd1, PM_DEC = 2'd2, PM_RSV = 2'd3
  } post_mod_e;

  // upper half passes through, lower half is placed in the selected segment
  function automatic logic [PHYS_W-1:0] seg_extend(input logic [BYTE_W-1:0] seg,
                                                   input logic [BYTE_W-1:0] a);
    if (a[BYTE_W-1]) return {{BYTE_W{1'b0}}, a};
    return {seg, 1'b0, a[BYTE_W-2:0]};
  endfunction

  // 8-bit pointer step, wrapping, no carry out
  function automatic logic [BYTE_W-1:0] ptr_step(input logic [BYTE_W-1:0] p,
                                                 input post_mod_e m);
    case (m)
      PM_INC:  return p + 1'b1;
      PM_DEC:  return p - 1'b1;
      default: return p;
    endcase
  endfunction
endpackage

// File: rtl/dmem_addr_gen.sv
module dmem_addr_gen
  import dmem_seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  addr_src_e         src,
  input  logic [BYTE_W-1:0] dir_addr,
  input  logic [BYTE_W-1:0] ptr_b,
  input  logic [BYTE_W-1:0] ptr_x,
  input  logic [BYTE_W-1:0] ptr_sp,
  input  logic [BYTE_W-1:0] seg,
  output logic [BYTE_W-1:0] eff_addr,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              is_mapped,
  output logic [3:0]        map_idx
);
  localparam logic [3:0] MAP_HI = 4'hF;

  always_comb begin
    case (src)
      SRC_B:   eff_addr = ptr_b;
      SRC_X:   eff_addr = ptr_x;
      SRC_SP:  eff_addr = ptr_sp;
      default: eff_addr = dir_addr;
    endcase
  end

  assign phys_addr = seg_extend(seg, eff_addr);
  assign is_mapped = (eff_addr[BYTE_W-1:4] == MAP_HI);
  assign map_idx   = eff_addr[3:0];

  // R2
  upper_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eff_addr[BYTE_W-1] |-> (phys_addr[PHYS_W-1:BYTE_W] == '0) && (phys_addr[BYTE_W-1:0] == eff_addr));
  // R1
  lower_segment_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eff_addr[BYTE_W-1] |-> (phys_addr[PHYS_W-1:BYTE_W] == seg) && !phys_addr[BYTE_W-1]);
endmodule

// File: rtl/dmem_map_regs.sv
module dmem_map_regs
  import dmem_seg_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SP_INIT = 8'h6F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              dsz_en,
  input  logic [3:0]        dsz_idx,
  input  logic              post_b_en,
  input  logic              post_x_en,
  input  post_mod_e         post_mode,
  input  logic [3:0]        rd_idx,
  output logic [BYTE_W-1:0] rd_val,
  output logic [BYTE_W-1:0] ptr_b,
  output logic [BYTE_W-1:0] ptr_x,
  output logic [BYTE_W-1:0] ptr_sp,
  output logic [BYTE_W-1:0] seg
);
  logic [BYTE_W-1:0] regs_q [NREG];
  logic              seg_load_evt;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [3:0]        MY_IDX = 4'(i);
    localparam logic [BYTE_W-1:0] RST_V  = (i == IDX_SP) ? SP_INIT : '0;
    logic post_hit;
    if (i == IDX_B) begin : g_pb
      assign post_hit = post_b_en;
    end else if (i == IDX_X) begin : g_px
      assign post_hit = post_x_en;
    end else begin : g_pn
      assign post_hit = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                            regs_q[i] <= RST_V;
      else if (post_hit)                     regs_q[i] <= ptr_step(regs_q[i], post_mode);
      else if (dsz_en && dsz_idx == MY_IDX)  regs_q[i] <= regs_q[i] - 1'b1;
      else if (wr_en && wr_idx == MY_IDX)    regs_q[i] <= wr_data;
    end
  end

  assign rd_val       = regs_q[rd_idx];
  assign ptr_b        = regs_q[IDX_B];
  assign ptr_x        = regs_q[IDX_X];
  assign ptr_sp       = regs_q[IDX_SP];
  assign seg          = regs_q[IDX_S];
  assign seg_load_evt = (wr_en && wr_idx == 4'(IDX_S)) || (dsz_en && dsz_idx == 4'(IDX_S));

  // R5
  b_post_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    post_b_en && post_mode == PM_INC |=> ptr_b == $past(ptr_b) + 8'd1);
  // R5
  x_post_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    post_x_en && post_mode == PM_DEC |=> ptr_x == $past(ptr_x) - 8'd1);
  // R5
  seg_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seg_load_evt |=> $stable(seg));
  // R11
  post_beats_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    post_b_en && wr_en && wr_idx == 4'(IDX_B) |=> ptr_b == ptr_step($past(ptr_b), $past(post_mode)));
endmodule

// File: rtl/dmem_rd_path.sv
module dmem_rd_path
  import dmem_seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic              rd_mapped,
  input  logic [BYTE_W-1:0] reg_val,
  input  logic              skip_next,
  input  logic [BYTE_W-1:0] ram_rdata,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              skip
);
  logic              mapped_q;
  logic [BYTE_W-1:0] reg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      mapped_q <= 1'b0;
      reg_q    <= '0;
      skip     <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      mapped_q <= rd_fire && rd_mapped;
      skip     <= skip_next;
      if (rd_fire && rd_mapped) reg_q <= reg_val;
    end
  end

  assign rd_data = mapped_q ? reg_q : ram_rdata;

  // R10
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rd_valid);
endmodule

// File: rtl/dmem_seg_unit.sv
module dmem_seg_unit
  import dmem_seg_pkg::*;
#(
  parameter int unsigned RAM_BYTES = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [2:0]  req_op,
  input  logic [1:0]  req_src,
  input  logic [1:0]  req_post,
  input  logic [7:0]  req_addr,
  input  logic [7:0]  req_wdata,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic        skip,
  output logic [15:0] ram_addr,
  output logic        ram_re,
  output logic        ram_we,
  output logic [7:0]  ram_wdata,
  input  logic [7:0]  ram_rdata
);
  localparam logic [BYTE_W-1:0] SP_RESET = (RAM_BYTES == 64) ? 8'h2F : 8'h6F;

  mem_op_e   op;
  addr_src_e src_sel;
  post_mod_e pm;
  logic is_rd, is_wr, is_ldi, is_dsz, is_access;
  logic dir_in_regs;
  logic [BYTE_W-1:0] eff_addr, rd_val, ptr_b, ptr_x, ptr_sp, seg;
  logic [PHYS_W-1:0] phys_addr;
  logic is_mapped;
  logic [3:0] map_idx;
  logic wr_en, dsz_en, post_b_en, post_x_en, skip_next;
  logic [3:0] wr_idx, rd_idx;

  assign op        = mem_op_e'(req_op);
  assign pm        = post_mod_e'(req_post);
  assign is_rd     = req_valid && op == OP_RD;
  assign is_wr     = req_valid && op == OP_WR;
  assign is_ldi    = req_valid && op == OP_LDI;
  assign is_dsz    = req_valid && op == OP_DSZ;
  assign is_access = is_rd || is_wr;
  // register-only operations always use the direct address
  assign src_sel   = is_access ? addr_src_e'(req_src) : SRC_DIR;
  assign dir_in_regs = (req_addr[7:4] == 4'hF) && (req_addr != 8'hFF);

  dmem_addr_gen u_agen (
    .clk(clk), .rst_n(rst_n), .src(src_sel), .dir_addr(req_addr),
    .ptr_b(ptr_b), .ptr_x(ptr_x), .ptr_sp(ptr_sp), .seg(seg),
    .eff_addr(eff_addr), .phys_addr(phys_addr), .is_mapped(is_mapped), .map_idx(map_idx)
  );

  assign wr_en     = (is_wr && is_mapped) || (is_ldi && dir_in_regs);
  assign wr_idx    = is_ldi ? req_addr[3:0] : map_idx;
  assign dsz_en    = is_dsz && dir_in_regs;
  assign rd_idx    = is_dsz ? req_addr[3:0] : map_idx;
  assign post_b_en = is_access && src_sel == SRC_B && pm != PM_NONE;
  assign post_x_en = is_access && src_sel == SRC_X && pm != PM_NONE;
  assign skip_next = dsz_en && (rd_val == 8'd1);

  dmem_map_regs #(.SP_INIT(SP_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(req_wdata),
    .dsz_en(dsz_en), .dsz_idx(req_addr[3:0]), .post_b_en(post_b_en), .post_x_en(post_x_en),
    .post_mode(pm), .rd_idx(rd_idx), .rd_val(rd_val), .ptr_b(ptr_b), .ptr_x(ptr_x),
    .ptr_sp(ptr_sp), .seg(seg)
  );

  dmem_rd_path u_rdp (
    .clk(clk), .rst_n(rst_n), .rd_fire(is_rd), .rd_mapped(is_mapped), .reg_val(rd_val),
    .skip_next(skip_next), .ram_rdata(ram_rdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .skip(skip)
  );

  assign ram_addr  = phys_addr;
  assign ram_re    = is_rd && !is_mapped;
  assign ram_we    = is_wr && !is_mapped;
  assign ram_wdata = req_wdata;

  // R3
  no_ram_for_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_re || ram_we) |-> !(ram_addr[15:8] == 8'h00 && ram_addr[7:4] == 4'hF));
  // R9
  dsz_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsz_en |=> skip == ($past(rd_val) == 8'd1));
  // R9
  skip_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dsz_en |=> !skip);
endmodule

// File: tb/dmem_seg_unit_tb.sv
module dmem_seg_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [1:0] req_src = '0;
  logic [1:0] req_post = '0;
  logic [7:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [7:0] rd_data, ram_wdata;
  logic rd_valid, skip, ram_re, ram_we;
  logic [15:0] ram_addr;
  logic [7:0] ram_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [15:0] c_addr;
  logic c_re, c_we, c_rv, c_skip;
  logic [7:0] c_rd;

  always #5 clk = ~clk;

  dmem_seg_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_src(req_src),
    .req_post(req_post), .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .skip(skip), .ram_addr(ram_addr), .ram_re(ram_re), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  function automatic logic [7:0] mdl(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h3C;
  endfunction

  always_ff @(posedge clk) ram_rdata <= mdl(ram_addr);

  function automatic logic [15:0] exp_phys(input logic [7:0] s, input logic [7:0] a);
    int v;
    if (a >= 8'h80) v = a;
    else v = s * 256 + (a & 8'h7F);
    return 16'(v);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] src, input logic [1:0] pm,
                       input logic [7:0] a, input logic [7:0] wd);
    req_valid = 1'b1; req_op = op; req_src = src; req_post = pm; req_addr = a; req_wdata = wd;
    #1;
    c_addr = ram_addr; c_re = ram_re; c_we = ram_we;
    @(negedge clk);
    req_valid = 1'b0; req_op = '0; req_post = '0;
    #1;
    c_rd = rd_data; c_rv = rd_valid; c_skip = skip;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] v);
    issue(3'd1, 2'd0, 2'd0, a, 8'h00);
    v = c_rd;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R6 rd_valid", {15'd0, rd_valid}, 16'd0);
    chk("R6 skip", {15'd0, skip}, 16'd0);
    rd_reg(8'hFD, v); chk("R6 SP", {8'd0, v}, 16'h006F);
    chk("R3 reg read no ram_re", {15'd0, c_re}, 16'd0);
    rd_reg(8'hFF, v); chk("R6 S", {8'd0, v}, 16'h0000);
    rd_reg(8'hFC, v); chk("R6 X", {8'd0, v}, 16'h0000);
    rd_reg(8'hFE, v); chk("R6 B", {8'd0, v}, 16'h0000);
    rd_reg(8'hF7, v); chk("R6 general", {8'd0, v}, 16'h0000);
  endtask

  task automatic t_direct();
    issue(3'd2, 2'd0, 2'd0, 8'hFF, 8'h05);
    chk("R3 S write no ram_we", {15'd0, c_we}, 16'd0);
    issue(3'd1, 2'd0, 2'd0, 8'h12, 8'h00);
    chk("R7 R1 addr after S write", c_addr, exp_phys(8'h05, 8'h12));
    chk("R10 ram_re", {15'd0, c_re}, 16'd1);
    chk("R10 rd_valid", {15'd0, c_rv}, 16'd1);
    chk("R10 rd_data", {8'd0, c_rd}, {8'd0, mdl(16'h0512)});
    issue(3'd2, 2'd0, 2'd0, 8'hFF, 8'hFF);
    issue(3'd2, 2'd0, 2'd0, 8'h7F, 8'h9A);
    chk("R1 top segment", c_addr, 16'hFF7F);
    chk("R1 ram_we", {15'd0, c_we}, 16'd1);
    chk("R1 ram_wdata", {8'd0, ram_wdata}, 16'h009A);
    issue(3'd1, 2'd0, 2'd0, 8'h00, 8'h00);
    chk("R1 segment base", c_addr, 16'hFF00);
  endtask

  task automatic t_upper();
    issue(3'd2, 2'd0, 2'd0, 8'hFF, 8'h33);
    issue(3'd1, 2'd0, 2'd0, 8'h85, 8'h00);
    chk("R2 0x85", c_addr, 16'h0085);
    chk("R2 rd_data", {8'd0, c_rd}, {8'd0, mdl(16'h0085)});
    issue(3'd2, 2'd0, 2'd0, 8'hEF, 8'h01);
    chk("R2 0xEF", c_addr, 16'h00EF);
    issue(3'd1, 2'd0, 2'd0, 8'h80, 8'h00);
    chk("R2 0x80", c_addr, 16'h0080);
  endtask

  task automatic t_mapped();
    logic [7:0] v;
    issue(3'd2, 2'd0, 2'd0, 8'hF3, 8'hA5);
    chk("R3 mapped write no ram_we", {15'd0, c_we}, 16'd0);
    rd_reg(8'hF3, v);
    chk("R3 general read back", {8'd0, v}, 16'h00A5);
    issue(3'd2, 2'd0, 2'd0, 8'hFB, 8'h5E);
    rd_reg(8'hFB, v);
    chk("R3 0xFB general", {8'd0, v}, 16'h005E);
  endtask

  task automatic t_indirect();
    issue(3'd2, 2'd0, 2'd0, 8'hFF, 8'h21);
    issue(3'd3, 2'd0, 2'd0, 8'hFE, 8'h40);
    issue(3'd1, 2'd1, 2'd0, 8'h00, 8'h00);
    chk("R4 via B", c_addr, exp_phys(8'h21, 8'h40));
    issue(3'd3, 2'd0, 2'd0, 8'hFC, 8'h90);
    issue(3'd2, 2'd2, 2'd0, 8'h00, 8'h77);
    chk("R4 via X upper", c_addr, 16'h0090);
    issue(3'd1, 2'd3, 2'd0, 8'h00, 8'h00);
    chk("R4 via SP", c_addr, exp_phys(8'h21, 8'h6F));
    chk("R4 via SP data", {8'd0, c_rd}, {8'd0, mdl(exp_phys(8'h21, 8'h6F))});
  endtask

  task automatic t_post();
    logic [7:0] v;
    issue(3'd3, 2'd0, 2'd0, 8'hFE, 8'h7F);
    issue(3'd1, 2'd1, 2'd1, 8'h00, 8'h00);
    chk("R5 access uses old B", c_addr, exp_phys(8'h21, 8'h7F));
    rd_reg(8'hFE, v); chk("R5 B incremented", {8'd0, v}, 16'h0080);
    issue(3'd3, 2'd0, 2'd0, 8'hFC, 8'h00);
    issue(3'd2, 2'd2, 2'd2, 8'h00, 8'h11);
    chk("R5 access uses old X", c_addr, exp_phys(8'h21, 8'h00));
    rd_reg(8'hFC, v); chk("R5 X wraps down", {8'd0, v}, 16'h00FF);
    issue(3'd3, 2'd0, 2'd0, 8'hFE, 8'hFF);
    issue(3'd1, 2'd1, 2'd1, 8'h00, 8'h00);
    rd_reg(8'hFE, v); chk("R5 B wraps up", {8'd0, v}, 16'h0000);
    rd_reg(8'hFF, v); chk("R5 no carry into S", {8'd0, v}, 16'h0021);
    issue(3'd1, 2'd3, 2'd1, 8'h00, 8'h00);
    rd_reg(8'hFD, v); chk("R5 SP unaffected by post", {8'd0, v}, 16'h006F);
    issue(3'd1, 2'd0, 2'd1, 8'hFE, 8'h00);
    rd_reg(8'hFE, v); chk("R5 direct unaffected by post", {8'd0, v}, 16'h0000);
  endtask

  task automatic t_ldi();
    logic [7:0] v;
    issue(3'd3, 2'd0, 2'd0, 8'hF0, 8'h12);
    rd_reg(8'hF0, v); chk("R8 load F0", {8'd0, v}, 16'h0012);
    issue(3'd3, 2'd0, 2'd0, 8'hFF, 8'h77);
    rd_reg(8'hFF, v); chk("R8 S not loaded", {8'd0, v}, 16'h0021);
    issue(3'd3, 2'd0, 2'd0, 8'h30, 8'h44);
    chk("R8 low addr no ram_we", {15'd0, c_we}, 16'd0);
    chk("R8 low addr no ram_re", {15'd0, c_re}, 16'd0);
  endtask

  task automatic t_dsz();
    logic [7:0] v;
    issue(3'd3, 2'd0, 2'd0, 8'hF5, 8'h02);
    issue(3'd4, 2'd0, 2'd0, 8'hF5, 8'h00);
    chk("R9 skip low at 1", {15'd0, c_skip}, 16'd0);
    rd_reg(8'hF5, v); chk("R9 value 1", {8'd0, v}, 16'h0001);
    issue(3'd4, 2'd0, 2'd0, 8'hF5, 8'h00);
    chk("R9 skip at zero", {15'd0, c_skip}, 16'd1);
    rd_reg(8'hF5, v); chk("R9 value 0", {8'd0, v}, 16'h0000);
    issue(3'd4, 2'd0, 2'd0, 8'hF5, 8'h00);
    chk("R9 wrap no skip", {15'd0, c_skip}, 16'd0);
    rd_reg(8'hF5, v); chk("R9 wrap value", {8'd0, v}, 16'h00FF);
    issue(3'd2, 2'd0, 2'd0, 8'hFF, 8'h01);
    issue(3'd4, 2'd0, 2'd0, 8'hFF, 8'h00);
    chk("R9 S not decremented skip", {15'd0, c_skip}, 16'd0);
    rd_reg(8'hFF, v); chk("R9 S unchanged", {8'd0, v}, 16'h0001);
  endtask

  task automatic t_conflict();
    logic [7:0] v;
    issue(3'd3, 2'd0, 2'd0, 8'hFE, 8'hFE);
    issue(3'd2, 2'd1, 2'd1, 8'h00, 8'h11);
    chk("R11 no ram_we on self", {15'd0, c_we}, 16'd0);
    rd_reg(8'hFE, v); chk("R11 post wins", {8'd0, v}, 16'h00FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_direct();
    t_upper();
    t_mapped();
    t_indirect();
    t_post();
    t_ldi();
    t_dsz();
    t_conflict();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule